// File: doc/BRIEF.md
# Per-Frame Serial CRC Checker

This block watches a serial configuration stream that is cut into frames of fixed length. Each frame is a run of data bits followed by a 16-bit check value that was computed before transmission. As the data bits arrive, one per cycle whenever the valid strobe is high, the block folds them into a CRC-16 register. When the data field ends, the register itself supplies the expected check value. Each incoming check bit is compared against it as the bit arrives.

A single active-low status line reports the health of the whole stream. It drops as soon as any check bit of any frame disagrees with the computed value. It stays low until a new configuration start or a reset. For each frame the block also gives a one-cycle done pulse with a pass/fail flag, so a loader can see which frame went wrong. The data-field length is a parameter, so the same block serves streams whose frames differ in size.

Top module: `frame_crc_checker`

## Requirements
- R1: After `rst_n` low (synchronous) or a cycle with `cfg_start` high, `cfg_ok_n` is 1, `frame_done` is 0 and `frame_pass` is 0 in the following cycle; `cfg_start` takes priority over a valid bit in the same cycle.
- R2: The check value is CRC-16 with polynomial 0x1021, preset to 0xFFFF at the start of every frame, no final inversion. Data bits are fed MSB first, one per cycle with `bit_vld` high, and the check field is also sent MSB first. For the nine ASCII bytes "123456789" the value is 0x29B1. A frame whose check field matches gives `frame_pass` = 1 with `frame_done`, and `cfg_ok_n` stays 1.
- R3: A frame whose check field differs from the computed value in any bit gives `frame_pass` = 0 with `frame_done`, and `cfg_ok_n` is 0 from then on.
- R4: `cfg_ok_n` falls in the cycle after the clock edge that samples the first check bit differing from the computed value, without waiting for the end of the frame. Before that edge it is still 1.
- R5: Once `cfg_ok_n` is 0 it stays 0 through later frames, including correct ones, until `cfg_start` or `rst_n`.
- R6: `frame_done` is high for exactly one cycle, the cycle after the edge that samples the 16th check bit of a frame. `frame_pass` is 0 whenever `frame_done` is 0.
- R7: Cycles with `bit_vld` low are ignored: they do not advance the frame position, do not change the CRC, and do not produce `frame_done`, whatever `bit_in` holds.
- R8: Every frame is checked on its own. A failing frame does not make the next correct frame report `frame_pass` = 0.
- R9: `cfg_start` in the middle of a frame discards the partial frame. The next valid bit is the first data bit of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | 1 | Start of a new configuration stream; clears all state |
| bit_in | input | 1 | Serial stream bit |
| bit_vld | input | 1 | `bit_in` carries a stream bit this cycle |
| cfg_ok_n | output | 1 | Active-low stream status; low after any check mismatch |
| frame_done | output | 1 | One-cycle pulse after each frame's check field |
| frame_pass | output | 1 | With `frame_done`: 1 if that frame's check field matched |

## Verification
A fixed frame built from the string "123456789" with the published value 0x29B1 pins down the polynomial, the preset and the bit order, which a bench-side model alone could not. Random frames are sent with and without idle gaps. The gaps separate a counter that moves only on valid bits from one that moves on every cycle. Frames with a flipped check bit, at the first, last or a random position, or with a flipped data bit, show that the status drops at the right bit rather than at the frame end. Good frames sent after a bad one, together with a configuration start in the middle of a frame, tell per-frame independence apart from the sticky stream status and confirm that the restart discards the partial frame.

// File: rtl/fcc_pkg.sv
// Shared width, types and the single-bit CRC step used by the frame checker.
// Assumes a 16-bit CRC register shifted MSB first.
package fcc_pkg;

    localparam int unsigned CRC_W = 16;

    typedef logic [CRC_W-1:0] crc_t;

    localparam crc_t DEF_POLY = 16'h1021;
    localparam crc_t DEF_SEED = 16'hFFFF;

    // One step of a left-shifting CRC register for one serial bit.
    function automatic crc_t crc_step(input crc_t cur, input logic din, input crc_t poly);
        logic fb;
        fb = cur[CRC_W-1] ^ din;
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/fcc_bit_counter.sv
// Frame position counter. Counts valid bits from 0 to DATA_BITS+CRC_W-1 and
// wraps to 0 after the last check bit. Reports whether the current bit lies in
// the check field and whether it is the final bit of the frame.
// Assumes DATA_BITS >= 1; idle cycles (bit_vld low) leave the position alone.
module fcc_bit_counter
    import fcc_pkg::*;
#(
    parameter int unsigned DATA_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_start,
    input  logic bit_vld,
    output logic in_check,
    output logic last_bit
);

    localparam int unsigned TOTAL = DATA_BITS + CRC_W;
    localparam int unsigned POS_W = $clog2(TOTAL);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(TOTAL - 1);
    localparam logic [POS_W-1:0] CHECK_POS = POS_W'(DATA_BITS);

    logic [POS_W-1:0] pos_q;

    // Advance on each valid bit, wrap at the frame end, clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_start) begin
            pos_q <= '0;
        end else if (bit_vld) begin
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
        end
    end

    // Decode the field of the current position.
    always_comb begin
        in_check = (pos_q >= CHECK_POS);
        last_bit = (pos_q == LAST_POS);
    end

    a_r6_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST_POS);

    a_r7_idle_holds_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld && !cfg_start) |=> $stable(pos_q));

    a_r9_restart_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> (pos_q == '0));

endmodule

// File: rtl/fcc_crc_engine.sv
// CRC shift register. In the data field each valid bit is folded in through the
// polynomial. In the check field the register shifts out its expected value MSB
// first, and the incoming check bit is compared at the feedback point; a
// difference raises bit_mismatch for that cycle. Preset at every frame start.
// Assumes in_check and last_bit come from the frame position counter.
module fcc_crc_engine
    import fcc_pkg::*;
#(
    parameter crc_t POLY = DEF_POLY,
    parameter crc_t SEED = DEF_SEED
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_start,
    input  logic bit_vld,
    input  logic bit_in,
    input  logic in_check,
    input  logic last_bit,
    output crc_t crc_q,
    output logic bit_mismatch
);

    logic fb;

    // Feedback bit: shared by the data fold and the check comparison.
    always_comb begin
        fb           = crc_q[CRC_W-1] ^ bit_in;
        bit_mismatch = bit_vld && in_check && fb;
    end

    // Fold data bits, shift out the expected value, preset per frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_start) begin
            crc_q <= SEED;
        end else if (bit_vld) begin
            if (last_bit) begin
                crc_q <= SEED;
            end else if (in_check) begin
                crc_q <= {crc_q[CRC_W-2:0], 1'b0};
            end else begin
                crc_q <= crc_step(crc_q, bit_in, POLY);
            end
        end
    end

    a_r7_idle_holds_crc: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld && !cfg_start) |=> $stable(crc_q));

    a_r2_preset_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> (crc_q == SEED));

endmodule

// File: rtl/fcc_verdict.sv
// Frame and stream verdict. Latches a per-frame error on any check-bit
// mismatch, issues a one-cycle done pulse with a pass flag after the last
// check bit, and holds the active-low stream status low once any mismatch
// has been seen. Assumes mismatch is only raised on valid check-field bits.
module fcc_verdict (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_start,
    input  logic bit_vld,
    input  logic last_bit,
    input  logic bit_mismatch,
    output logic cfg_ok_n,
    output logic frame_done,
    output logic frame_pass
);

    logic frame_err_q;

    // Track frame error, stream status and the end-of-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_start) begin
            cfg_ok_n    <= 1'b1;
            frame_err_q <= 1'b0;
            frame_done  <= 1'b0;
            frame_pass  <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            frame_pass <= 1'b0;
            if (bit_mismatch) begin
                cfg_ok_n <= 1'b0;
            end
            if (bit_vld && last_bit) begin
                frame_done  <= 1'b1;
                frame_pass  <= !(frame_err_q || bit_mismatch);
                frame_err_q <= 1'b0;
            end else if (bit_mismatch) begin
                frame_err_q <= 1'b1;
            end
        end
    end

    a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> (cfg_ok_n && !frame_done && !frame_pass));

    a_r5_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ok_n && !cfg_start) |=> !cfg_ok_n);

    a_r4_drop_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_mismatch && !cfg_start) |=> !cfg_ok_n);

    a_r3_fail_implies_low: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_pass) |-> !cfg_ok_n);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    a_r6_pass_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pass |-> frame_done);

endmodule

// File: rtl/frame_crc_checker.sv
// Per-frame serial CRC checker top. Wires the frame position counter, the CRC
// engine and the verdict logic together. Assumes one stream bit per cycle
// with bit_vld high and frames of DATA_BITS data bits plus a 16-bit check.
module frame_crc_checker
    import fcc_pkg::*;
#(
    parameter int unsigned DATA_BITS = 64,
    parameter crc_t        POLY      = DEF_POLY,
    parameter crc_t        SEED      = DEF_SEED
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_start,
    input  logic bit_in,
    input  logic bit_vld,
    output logic cfg_ok_n,
    output logic frame_done,
    output logic frame_pass
);

    logic in_check;
    logic last_bit;
    logic bit_mismatch;
    crc_t crc_q;

    fcc_bit_counter #(
        .DATA_BITS (DATA_BITS)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_start (cfg_start),
        .bit_vld   (bit_vld),
        .in_check  (in_check),
        .last_bit  (last_bit)
    );

    fcc_crc_engine #(
        .POLY (POLY),
        .SEED (SEED)
    ) u_crc (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_start    (cfg_start),
        .bit_vld      (bit_vld),
        .bit_in       (bit_in),
        .in_check     (in_check),
        .last_bit     (last_bit),
        .crc_q        (crc_q),
        .bit_mismatch (bit_mismatch)
    );

    fcc_verdict u_verdict (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_start    (cfg_start),
        .bit_vld      (bit_vld),
        .last_bit     (last_bit),
        .bit_mismatch (bit_mismatch),
        .cfg_ok_n     (cfg_ok_n),
        .frame_done   (frame_done),
        .frame_pass   (frame_pass)
    );

    // The engine must be preset whenever a frame has just closed.
    a_r8_preset_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (crc_q == SEED));

    // Mismatches only arise inside the check field.
    a_r3_mismatch_in_check: assert property (@(posedge clk) disable iff (!rst_n)
        bit_mismatch |-> in_check);

endmodule

// File: tb/frame_crc_checker_tb.sv
module frame_crc_checker_tb;

    localparam int DB = 72;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_start = 1'b0;
    logic bit_in = 1'b0;
    logic bit_vld = 1'b0;
    logic cfg_ok_n;
    logic frame_done;
    logic frame_pass;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit finished = 1'b0;
    bit exp_ok_n = 1'b1;
    bit gaps_on = 1'b0;

    always #4 clk = ~clk;

    frame_crc_checker #(.DATA_BITS(DB)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_start  (cfg_start),
        .bit_in     (bit_in),
        .bit_vld    (bit_vld),
        .cfg_ok_n   (cfg_ok_n),
        .frame_done (frame_done),
        .frame_pass (frame_pass)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "watchdog", cycles, 150000);
            finish_run();
        end
    end

    // CRC-16, poly 0x1021, seed 0xFFFF, MSB first, no final inversion (R2).
    function automatic logic [15:0] ref_crc(input logic [DB-1:0] d);
        logic [15:0] r;
        r = 16'hFFFF;
        for (int i = DB - 1; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic idle_cycle();
        @(negedge clk);
        bit_vld = 1'b0;
        bit_in  = 1'($urandom);
        @(posedge clk);
        #1;
        chk(frame_done == 1'b0, "R7 idle no done", frame_done, 0);
        chk(cfg_ok_n == exp_ok_n, "R7 idle status", cfg_ok_n, exp_ok_n);
    endtask

    task automatic send_bit(input logic b);
        if (gaps_on && ($urandom % 4 == 0)) idle_cycle();
        @(negedge clk);
        bit_in  = b;
        bit_vld = 1'b1;
        @(posedge clk);
        #1;
    endtask

    // Send a frame with a given check field; verify per-bit status and verdict.
    task automatic send_frame(input logic [DB-1:0] d, input logic [15:0] chkv);
        logic [15:0] good;
        good = ref_crc(d);
        for (int i = DB - 1; i >= 0; i--) begin
            send_bit(d[i]);
            chk(frame_done == 1'b0, "R6 no done in data", frame_done, 0);
        end
        for (int j = 15; j >= 0; j--) begin
            send_bit(chkv[j]);
            if (chkv[j] != good[j]) exp_ok_n = 1'b0;
            chk(cfg_ok_n == exp_ok_n, "R4 status per check bit", cfg_ok_n, exp_ok_n);
            if (j == 0) begin
                chk(frame_done == 1'b1, "R6 done pulse", frame_done, 1);
                chk(frame_pass == (chkv == good), (chkv == good) ? "R2 pass" : "R3 fail",
                    frame_pass, int'(chkv == good));
            end else begin
                chk(frame_done == 1'b0, "R6 no early done", frame_done, 0);
            end
        end
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic pulse_start(input bit with_vld);
        @(negedge clk);
        cfg_start = 1'b1;
        bit_vld   = with_vld;
        bit_in    = 1'($urandom);
        @(posedge clk);
        #1;
        exp_ok_n = 1'b1;
        chk(cfg_ok_n == 1'b1, "R1 start status", cfg_ok_n, 1);
        chk(frame_done == 1'b0, "R1 start done", frame_done, 0);
        chk(frame_pass == 1'b0, "R1 start pass", frame_pass, 0);
        @(negedge clk);
        cfg_start = 1'b0;
        bit_vld   = 1'b0;
    endtask

    function automatic logic [DB-1:0] rnd_data();
        return {$urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [DB-1:0] d;
        logic [15:0] c;
        void'($urandom(32'd20240611));

        // R1: reset state.
        repeat (3) @(posedge clk);
        #1;
        chk(cfg_ok_n == 1'b1, "R1 reset status", cfg_ok_n, 1);
        chk(frame_done == 1'b0, "R1 reset done", frame_done, 0);
        chk(frame_pass == 1'b0, "R1 reset pass", frame_pass, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: known vector "123456789" -> 0x29B1.
        d = 72'h31_32_33_34_35_36_37_38_39;
        send_frame(d, 16'h29B1);

        // R7: same frame with idle gaps, random bit_in in gaps.
        gaps_on = 1'b1;
        send_frame(d, 16'h29B1);

        // R2/R8: random good frames.
        for (int k = 0; k < 10; k++) begin
            d = rnd_data();
            send_frame(d, ref_crc(d));
        end
        chk(cfg_ok_n == 1'b1, "R2 status after good frames", cfg_ok_n, 1);

        // R4: only the last check bit wrong; status drops at the end.
        d = rnd_data();
        c = ref_crc(d) ^ 16'h0001;
        send_frame(d, c);

        // R5/R8: good frame after a failure passes, status stays low.
        d = rnd_data();
        send_frame(d, ref_crc(d));
        chk(cfg_ok_n == 1'b0, "R5 sticky status", cfg_ok_n, 0);

        pulse_start(1'b0);

        // R3/R4: first check bit wrong.
        d = rnd_data();
        send_frame(d, ref_crc(d) ^ 16'h8000);
        pulse_start(1'b1);

        // R3: data bit corrupted relative to the check field.
        d = rnd_data();
        c = ref_crc(d);
        send_frame(d ^ (72'd1 << ($urandom % DB)), c);

        // R9: restart mid-frame discards a partial frame.
        pulse_start(1'b0);
        for (int i = 0; i < 40; i++) send_bit(1'($urandom));
        pulse_start(1'b1);
        d = rnd_data();
        send_frame(d, ref_crc(d));
        chk(cfg_ok_n == 1'b1, "R9 status after restart", cfg_ok_n, 1);

        // R5: sticky survives many good frames; reset clears it (R1).
        d = rnd_data();
        send_frame(d, ref_crc(d) ^ (16'd1 << ($urandom % 16)));
        for (int k = 0; k < 3; k++) begin
            d = rnd_data();
            send_frame(d, ref_crc(d));
        end
        chk(cfg_ok_n == 1'b0, "R5 sticky after several", cfg_ok_n, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        exp_ok_n = 1'b1;
        chk(cfg_ok_n == 1'b1, "R1 reset clears status", cfg_ok_n, 1);
        @(negedge clk);
        rst_n = 1'b1;

        // Random mix of good and corrupted frames with occasional restarts.
        for (int k = 0; k < 40; k++) begin
            d = rnd_data();
            c = ref_crc(d);
            if ($urandom % 10 < 3) c = c ^ (16'd1 << ($urandom % 16));
            gaps_on = ($urandom % 2) == 1;
            send_frame(d, c);
            if ($urandom % 8 == 0) pulse_start(1'($urandom));
        end

        idle_cycle();
        finish_run();
    end

endmodule